// File: doc/BRIEF.md
# Serial Display PLL Enable Sequencer

This block brings a serial display link out of power-down and back into it without software polling. On a start command it turns on the free-running pixel clock and puts the link PLL into system reset. After a short settle time it raises a GO request to the PLL. It waits for that request to be accepted, waits for lock, turns on the LCD output, and finally waits for the link to report that its own reset has completed. When the last condition is met the block reports done and stays in the link-up state until a stop command takes the link down in a fixed order.

Each of the three waits has its own timeout, counted in clock cycles. A timeout aborts the bring-up. The steps already taken are undone one per cycle, and how far back the unwind reaches depends on which wait expired. A one-cycle error pulse ends the unwind. Two sticky flags keep the outcome of the most recent bring-up.

Beside the sequencer, a small configuration latch holds the link's static settings. It accepts a data-pair count from 1 to 3 and stores it together with fixed divider and PLL multiplier values. Any other count is refused and the stored settings are left unchanged.

Top module: `sdl_pll_seq`

## Requirements
- R1: After reset all control outputs, pulses, sticky result flags and configuration fields read zero.
- R2: A start in idle raises pixel clock enable one cycle after start is sampled and PLL reset on the next cycle. GO rises after PLL reset has been high for SETTLE_CYC cycles, and GO is never high without both of them.
- R3: GO stays high while request-pending reads 1 and falls the cycle after request-pending is sampled 0.
- R4: LCD enable rises the cycle after PLL locked is sampled 1 in the lock wait, and only after GO has fallen.
- R5: Done pulses the cycle after reset-complete is sampled 1 with LCD enable high. This sets the sticky success flag and clears the sticky error flag, and all three enables stay on.
- R6: Each wait evaluates its status on TIMEOUT_CYC consecutive cycles. Status seen on the last of them counts as success, and status that arrives one cycle later gives a timeout.
- R7: A timeout in the request or lock wait clears PLL reset and GO together, then clears pixel clock enable one cycle later with the error pulse. LCD enable is never raised.
- R8: A timeout in the reset-complete wait clears LCD enable, then PLL reset, then pixel clock enable with the error pulse, one step per cycle.
- R9: A stop in the link-up state clears LCD enable, then pixel clock enable, then PLL reset, one step per cycle. LCD enable is never high without the pixel clock.
- R10: Start is ignored unless the sequencer is idle, and stop is ignored unless the link is up. An ignored command changes no output and no timing.
- R11: Done and error are one-cycle pulses. An error sets the sticky error flag and clears the sticky success flag, and both flags hold until the next outcome.
- R12: A configuration load with a pair count of 1, 2 or 3 stores count minus one in the 2-bit pair field. It also stores pixel divider 0xF (5 bits), bandwidth select 2 (2 bits), frequency select 7 (4 bits), PLL N 0xB (6 bits) and PLL M 0xB4 (10 bits).
- R13: A configuration load with a pair count of 0 or 4 to 7 pulses cfg_bad for one cycle and leaves every configuration field unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the bring-up (idle only) |
| stop | input | 1 | Take the link down (link-up only) |
| st_req_pend | input | 1 | PLL status: GO request still pending |
| st_locked | input | 1 | PLL status: locked |
| st_rst_done | input | 1 | Link status: link reset complete |
| cfg_load | input | 1 | Load configuration this cycle |
| cfg_pairs | input | 3 | Requested data-pair count |
| pck_free_en | output | 1 | Free-running pixel clock enable |
| pll_sys_rst | output | 1 | PLL system reset control |
| pll_go | output | 1 | PLL GO request |
| lcd_en | output | 1 | LCD output enable |
| done | output | 1 | One-cycle bring-up success pulse |
| err | output | 1 | One-cycle timeout pulse, end of unwind |
| res_ok | output | 1 | Sticky: last outcome was success |
| res_err | output | 1 | Sticky: last outcome was timeout |
| cfg_bad | output | 1 | One-cycle pulse: configuration refused |
| cfg_pair_sel | output | 2 | Stored pair count minus one |
| cfg_pix_div | output | 5 | Stored pixel divider |
| cfg_bw_sel | output | 2 | Stored bandwidth select |
| cfg_freq_sel | output | 4 | Stored PLL frequency select |
| cfg_pll_n | output | 6 | Stored PLL N value |
| cfg_pll_m | output | 10 | Stored PLL M value |

## Verification
The bench targets the last-cycle boundary of the request and lock waits. If the timeout is checked ahead of the status, or the counter is off by one, status that arrives on the final cycle is reported as a failure, or a late status is accepted. Each timeout stage is run separately and the cycle at which every enable drops is recorded. A design that shares one unwind path would drop LCD enable where it must not, or would drop pixel clock and PLL reset in the wrong order. Stray start and stop pulses are injected in the middle of a bring-up, which shows whether the design restarts or aborts by mistake. Out-of-range pair counts show whether a refused load still changes the stored fields.

// File: rtl/sdl_seq_pkg.sv
`timescale 1ns/1ps
package sdl_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PCK,
    ST_SETTLE,
    ST_REQ,
    ST_LOCK,
    ST_RDONE,
    ST_UP,
    ST_DN_PCK,
    ST_DN_RST,
    ST_EU_LCD,
    ST_EU_RST,
    ST_EU_PCK
  } seq_state_e;

  localparam int PAIR_W = 2;
  localparam int PDIV_W = 5;
  localparam int BW_W   = 2;
  localparam int FSEL_W = 4;
  localparam int N_W    = 6;
  localparam int M_W    = 10;

  localparam logic [PDIV_W-1:0] PDIV_VAL = 5'h0F;
  localparam logic [BW_W-1:0]   BW_VAL   = 2'd2;
  localparam logic [FSEL_W-1:0] FSEL_VAL = 4'd7;
  localparam logic [N_W-1:0]    N_VAL    = 6'h0B;
  localparam logic [M_W-1:0]    M_VAL    = 10'h0B4;

  // a wait of n evaluation cycles loads n-1 into the down-counter
  function automatic int wait_load(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic logic pairs_ok(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd3);
  endfunction

  function automatic logic [PAIR_W-1:0] pairs_code(input logic [2:0] c);
    logic [2:0] m;
    m = c - 3'd1;
    return m[PAIR_W-1:0];
  endfunction

endpackage

// File: rtl/sdl_seq_timer.sv
`timescale 1ns/1ps
module sdl_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R6
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdl_seq_cfg.sv
`timescale 1ns/1ps
module sdl_seq_cfg
  import sdl_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        pairs,
  output logic [PAIR_W-1:0] pair_sel,
  output logic [PDIV_W-1:0] pix_div,
  output logic [BW_W-1:0]   bw_sel,
  output logic [FSEL_W-1:0] freq_sel,
  output logic [N_W-1:0]    pll_n,
  output logic [M_W-1:0]    pll_m,
  output logic              bad
);

  logic accept;
  assign accept = load && pairs_ok(pairs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_sel <= '0;
      pix_div  <= '0;
      bw_sel   <= '0;
      freq_sel <= '0;
      pll_n    <= '0;
      pll_m    <= '0;
      bad      <= 1'b0;
    end else begin
      bad <= load && !accept;
      if (accept) begin
        pair_sel <= pairs_code(pairs);
        pix_div  <= PDIV_VAL;
        bw_sel   <= BW_VAL;
        freq_sel <= FSEL_VAL;
        pll_n    <= N_VAL;
        pll_m    <= M_VAL;
      end
    end
  end

  // R13
  bad_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> ($stable(pair_sel) && $stable(pix_div) && $stable(pll_m) && $stable(pll_n)));

endmodule

// File: rtl/sdl_pll_seq.sv
`timescale 1ns/1ps
module sdl_pll_seq
  import sdl_seq_pkg::*;
#(
  parameter int TIMEOUT_CYC = 50000000,
  parameter int SETTLE_CYC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        stop,
  input  logic        st_req_pend,
  input  logic        st_locked,
  input  logic        st_rst_done,
  input  logic        cfg_load,
  input  logic [2:0]  cfg_pairs,
  output logic        pck_free_en,
  output logic        pll_sys_rst,
  output logic        pll_go,
  output logic        lcd_en,
  output logic        done,
  output logic        err,
  output logic        res_ok,
  output logic        res_err,
  output logic        cfg_bad,
  output logic [1:0]  cfg_pair_sel,
  output logic [4:0]  cfg_pix_div,
  output logic [1:0]  cfg_bw_sel,
  output logic [3:0]  cfg_freq_sel,
  output logic [5:0]  cfg_pll_n,
  output logic [9:0]  cfg_pll_m
);

  localparam int MAXC = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WAIT_LD   = CW'(wait_load(TIMEOUT_CYC));
  localparam logic [CW-1:0] SETTLE_LD = CW'(wait_load(SETTLE_CYC));

  seq_state_e state;

  // named events shared by the FSM and the assertions
  logic tmr_exp, tmr_load;
  logic [CW-1:0] tmr_val;
  logic settle_end, req_ack, lock_seen, rdone_seen, wait_tmo;

  assign settle_end = (state == ST_SETTLE) && tmr_exp;
  assign req_ack    = (state == ST_REQ)   && !st_req_pend;
  assign lock_seen  = (state == ST_LOCK)  && st_locked;
  assign rdone_seen = (state == ST_RDONE) && st_rst_done;
  assign wait_tmo   = tmr_exp &&
                      (((state == ST_REQ)   && !req_ack)   ||
                       ((state == ST_LOCK)  && !lock_seen) ||
                       ((state == ST_RDONE) && !rdone_seen));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = WAIT_LD;
    if (state == ST_PCK) begin
      tmr_load = 1'b1;
      tmr_val  = SETTLE_LD;
    end else if (settle_end || req_ack || lock_seen) begin
      tmr_load = 1'b1;
    end
  end

  sdl_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sdl_seq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .pairs    (cfg_pairs),
    .pair_sel (cfg_pair_sel),
    .pix_div  (cfg_pix_div),
    .bw_sel   (cfg_bw_sel),
    .freq_sel (cfg_freq_sel),
    .pll_n    (cfg_pll_n),
    .pll_m    (cfg_pll_m),
    .bad      (cfg_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pck_free_en <= 1'b0;
      pll_sys_rst <= 1'b0;
      pll_go      <= 1'b0;
      lcd_en      <= 1'b0;
      done        <= 1'b0;
      err         <= 1'b0;
      res_ok      <= 1'b0;
      res_err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          pck_free_en <= 1'b1;
          state       <= ST_PCK;
        end
        ST_PCK: begin
          pll_sys_rst <= 1'b1;
          state       <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_end) begin
          pll_go <= 1'b1;
          state  <= ST_REQ;
        end
        ST_REQ: if (req_ack) begin
          pll_go <= 1'b0;
          state  <= ST_LOCK;
        end else if (wait_tmo) begin
          state <= ST_EU_RST;
        end
        ST_LOCK: if (lock_seen) begin
          lcd_en <= 1'b1;
          state  <= ST_RDONE;
        end else if (wait_tmo) begin
          state <= ST_EU_RST;
        end
        ST_RDONE: if (rdone_seen) begin
          done    <= 1'b1;
          res_ok  <= 1'b1;
          res_err <= 1'b0;
          state   <= ST_UP;
        end else if (wait_tmo) begin
          state <= ST_EU_LCD;
        end
        ST_UP: if (stop) begin
          lcd_en <= 1'b0;
          state  <= ST_DN_PCK;
        end
        ST_DN_PCK: begin
          pck_free_en <= 1'b0;
          state       <= ST_DN_RST;
        end
        ST_DN_RST: begin
          pll_sys_rst <= 1'b0;
          state       <= ST_IDLE;
        end
        ST_EU_LCD: begin
          lcd_en <= 1'b0;
          state  <= ST_EU_RST;
        end
        ST_EU_RST: begin
          pll_sys_rst <= 1'b0;
          pll_go      <= 1'b0;
          state       <= ST_EU_PCK;
        end
        ST_EU_PCK: begin
          pck_free_en <= 1'b0;
          err         <= 1'b1;
          res_ok      <= 1'b0;
          res_err     <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  go_needs_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_go |-> (pll_sys_rst && pck_free_en));

  // R3
  go_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_go) && pll_sys_rst) |-> !$past(st_req_pend));

  // R4
  lcd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($past(st_locked) && !pll_go));

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st_rst_done) && lcd_en && res_ok));

  // R9
  lcd_needs_pck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> (pck_free_en && pll_sys_rst));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!err && !res_ok && res_err));

endmodule

// File: tb/sdl_pll_seq_test.sv
`timescale 1ns/1ps
module sdl_pll_seq_test;

  localparam int TMO   = 8;
  localparam int SET   = 2;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  logic rst_n, start, stop, st_req_pend, st_locked, st_rst_done, cfg_load;
  logic [2:0] cfg_pairs;
  logic pck_free_en, pll_sys_rst, pll_go, lcd_en, done, err, res_ok, res_err, cfg_bad;
  logic [1:0] cfg_pair_sel, cfg_bw_sel;
  logic [4:0] cfg_pix_div;
  logic [3:0] cfg_freq_sel;
  logic [5:0] cfg_pll_n;
  logic [9:0] cfg_pll_m;

  always #5 clk = ~clk;

  sdl_pll_seq #(.TIMEOUT_CYC(TMO), .SETTLE_CYC(SET)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .st_req_pend(st_req_pend), .st_locked(st_locked), .st_rst_done(st_rst_done),
    .cfg_load(cfg_load), .cfg_pairs(cfg_pairs),
    .pck_free_en(pck_free_en), .pll_sys_rst(pll_sys_rst), .pll_go(pll_go),
    .lcd_en(lcd_en), .done(done), .err(err), .res_ok(res_ok), .res_err(res_err),
    .cfg_bad(cfg_bad), .cfg_pair_sel(cfg_pair_sel), .cfg_pix_div(cfg_pix_div),
    .cfg_bw_sel(cfg_bw_sel), .cfg_freq_sel(cfg_freq_sel), .cfg_pll_n(cfg_pll_n),
    .cfg_pll_m(cfg_pll_m)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct {
    int fin; int kind;
    int pck_r; int rst_r; int go_r; int go_f; int lcd_r; int lcd_f; int rst_f; int pck_f;
  } trace_t;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one bring-up; times are negedge indices after start is sampled
  task automatic run_seq(input int req_drop, input int lock_at, input int rdone_at,
                         input int poke_at, output trace_t tr);
    logic p_pck, p_rst, p_go, p_lcd;
    tr = '{default: 0};
    p_pck = 0; p_rst = 0; p_go = 0; p_lcd = 0;
    st_req_pend = (req_drop != 0);
    st_locked   = (lock_at == 0);
    st_rst_done = (rdone_at == 0);
    @(negedge clk); start = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      if (pck_free_en && !p_pck) tr.pck_r = i;
      if (!pck_free_en && p_pck) tr.pck_f = i;
      if (pll_sys_rst && !p_rst) tr.rst_r = i;
      if (!pll_sys_rst && p_rst) tr.rst_f = i;
      if (pll_go && !p_go) tr.go_r = i;
      if (!pll_go && p_go) tr.go_f = i;
      if (lcd_en && !p_lcd) tr.lcd_r = i;
      if (!lcd_en && p_lcd) tr.lcd_f = i;
      p_pck = pck_free_en; p_rst = pll_sys_rst; p_go = pll_go; p_lcd = lcd_en;
      if (done) begin tr.kind = 1; tr.fin = i; break; end
      if (err)  begin tr.kind = 2; tr.fin = i; break; end
      if (i == req_drop) st_req_pend = 1'b0;
      if (i == lock_at)  st_locked = 1'b1;
      if (i == rdone_at) st_rst_done = 1'b1;
      if (i == poke_at) begin start = 1'b1; stop = 1'b1; end
    end
  endtask

  task automatic take_down();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R9 lcd off first", lcd_en, 0);
    chk("R9 pck still on", pck_free_en, 1);
    chk("R9 rst still on", pll_sys_rst, 1);
    @(negedge clk);
    chk("R9 pck off second", pck_free_en, 0);
    chk("R9 rst on second", pll_sys_rst, 1);
    @(negedge clk);
    chk("R9 rst off third", pll_sys_rst, 0);
    chk("R11 res_ok holds", res_ok, 1);
  endtask

  task automatic test_reset();
    chk("R1 pck", pck_free_en, 0); chk("R1 rst", pll_sys_rst, 0);
    chk("R1 go", pll_go, 0);       chk("R1 lcd", lcd_en, 0);
    chk("R1 done", done, 0);       chk("R1 err", err, 0);
    chk("R1 res_ok", res_ok, 0);   chk("R1 res_err", res_err, 0);
    chk("R1 pair", cfg_pair_sel, 0); chk("R1 m", cfg_pll_m, 0);
  endtask

  task automatic test_fast();
    trace_t tr;
    run_seq(0, 0, 0, 0, tr);
    chk("R2 pck rise", tr.pck_r, 1);
    chk("R2 rst rise", tr.rst_r, 2);
    chk("R2 go rise", tr.go_r, 2 + SET);
    chk("R3 go fall", tr.go_f, 3 + SET);
    chk("R4 lcd rise", tr.lcd_r, 4 + SET);
    chk("R5 kind", tr.kind, 1);
    chk("R5 cycle", tr.fin, 5 + SET);
    @(negedge clk);
    chk("R11 done pulse", done, 0);
    chk("R5 res_ok", res_ok, 1); chk("R5 res_err", res_err, 0);
    chk("R5 lcd stays", lcd_en, 1); chk("R5 pck stays", pck_free_en, 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 start in up lcd", lcd_en, 1);
      chk("R10 start in up done", done, 0);
      @(negedge clk);
    end
    take_down();
  endtask

  task automatic test_slow();
    trace_t tr;
    run_seq(6, 8, 11, 5, tr);
    chk("R3 go held", tr.go_f, 7);
    chk("R4 lcd rise slow", tr.lcd_r, 9);
    chk("R10 pokes ignored kind", tr.kind, 1);
    chk("R10 pokes ignored cycle", tr.fin, 12);
    take_down();
  endtask

  task automatic test_req_tmo();
    trace_t tr;
    run_seq(NEVER, 0, 0, 0, tr);
    chk("R7 req kind", tr.kind, 2);
    chk("R7 req cycle", tr.fin, 4 + SET + TMO);
    chk("R7 req go off", tr.go_f, 3 + SET + TMO);
    chk("R7 req rst off", tr.rst_f, 3 + SET + TMO);
    chk("R7 req pck off", tr.pck_f, 4 + SET + TMO);
    chk("R7 req lcd never", tr.lcd_r, 0);
    @(negedge clk);
    chk("R11 err pulse", err, 0);
    chk("R11 res_err", res_err, 1); chk("R11 res_ok", res_ok, 0);
  endtask

  task automatic test_lock_tmo();
    trace_t tr;
    run_seq(0, NEVER, 0, 0, tr);
    chk("R7 lock kind", tr.kind, 2);
    chk("R7 lock cycle", tr.fin, 5 + SET + TMO);
    chk("R7 lock rst off", tr.rst_f, 4 + SET + TMO);
    chk("R7 lock pck off", tr.pck_f, 5 + SET + TMO);
    chk("R7 lock lcd never", tr.lcd_r, 0);
  endtask

  task automatic test_rdone_tmo();
    trace_t tr;
    run_seq(0, 0, NEVER, 0, tr);
    chk("R8 kind", tr.kind, 2);
    chk("R8 cycle", tr.fin, 7 + SET + TMO);
    chk("R8 lcd rose", tr.lcd_r, 4 + SET);
    chk("R8 lcd off", tr.lcd_f, 5 + SET + TMO);
    chk("R8 rst off", tr.rst_f, 6 + SET + TMO);
    chk("R8 pck off", tr.pck_f, 7 + SET + TMO);
  endtask

  task automatic test_edges();
    trace_t tr;
    run_seq(0, 2 + SET + TMO, 0, 0, tr);
    chk("R6 lock last cycle ok", tr.kind, 1);
    chk("R6 lock last cycle time", tr.fin, 4 + SET + TMO);
    take_down();
    run_seq(0, 3 + SET + TMO, 0, 0, tr);
    chk("R6 lock one late", tr.kind, 2);
    run_seq(1 + SET + TMO, 0, 0, 0, tr);
    chk("R6 req last cycle ok", tr.kind, 1);
    chk("R6 req last go fall", tr.go_f, 2 + SET + TMO);
    take_down();
    run_seq(2 + SET + TMO, 0, 0, 0, tr);
    chk("R6 req one late", tr.kind, 2);
  endtask

  task automatic test_idle_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    for (int k = 0; k < 2; k++) begin
      chk("R10 stop idle pck", pck_free_en, 0);
      chk("R10 stop idle rst", pll_sys_rst, 0);
      @(negedge clk);
    end
  endtask

  task automatic cfg_write(input logic [2:0] v);
    cfg_pairs = v; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic test_cfg();
    @(negedge clk);
    cfg_write(3'd2);
    chk("R12 pair 2", cfg_pair_sel, 1);
    chk("R12 pdiv", cfg_pix_div, 'hF); chk("R12 bw", cfg_bw_sel, 2);
    chk("R12 fsel", cfg_freq_sel, 7);  chk("R12 n", cfg_pll_n, 'hB);
    chk("R12 m", cfg_pll_m, 'hB4);     chk("R12 no bad", cfg_bad, 0);
    cfg_write(3'd3); chk("R12 pair 3", cfg_pair_sel, 2);
    cfg_write(3'd1); chk("R12 pair 1", cfg_pair_sel, 0);
    cfg_write(3'd0);
    chk("R13 zero bad", cfg_bad, 1); chk("R13 zero keeps", cfg_pair_sel, 0);
    @(negedge clk); chk("R13 bad pulse", cfg_bad, 0);
    cfg_write(3'd3);
    cfg_write(3'd4);
    chk("R13 four bad", cfg_bad, 1); chk("R13 four keeps", cfg_pair_sel, 2);
    cfg_write(3'd7);
    chk("R13 seven bad", cfg_bad, 1); chk("R13 seven keeps m", cfg_pll_m, 'hB4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    st_req_pend = 1'b0; st_locked = 1'b0; st_rst_done = 1'b0;
    cfg_load = 1'b0; cfg_pairs = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_fast();
    test_slow();
    test_req_tmo();
    test_lock_tmo();
    test_rdone_tmo();
    test_edges();
    test_idle_stop();
    test_cfg();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule